// File: doc/BRIEF.md
# Prescaled Multi-Mode 16-bit Timer

This block is a 16-bit timer counter on a byte-wide register bus. Software sets an operating mode and a prescale divisor. The counter then advances on qualifying pulses of a `tick` input. The counter can hold, run freely over the full 16-bit range, run modulo a programmable terminal value, or run as a triangle that climbs to the terminal value and falls back to zero.

An overflow flag marks the terminal point of each period. The interrupt request is that flag ANDed with a mask bit. Three channel flags share the status byte and are set by external pulses. All four flags are cleared by writing 0 to them.

Software reads the 16-bit count as two bytes. Reading the low byte freezes a copy of the high byte, so the two halves always belong to the same instant.

The count sequencer is a three-state machine:
- `ST_HOLD`: the counter is held.
- `ST_UP`: the counter is rising.
- `ST_DOWN`: the counter is falling.

Its transitions:
- *enter-hold*: any state goes to `ST_HOLD` whenever the mode field is 00.
- *start*: `ST_HOLD` goes to `ST_UP` once the mode is non-zero.
- *turn-down*: `ST_UP` goes to `ST_DOWN` in triangle mode on an advance taken at or above the terminal value.
- *turn-up*: `ST_DOWN` goes to `ST_UP` on an advance taken at zero, on a counter clear, or when the mode leaves triangle.

Top module: `prescaled_timer16`

## Requirements
- R1: The divider field selects how many ticks make one counter advance: 00 gives 1, 01 gives 8, 10 gives 32 and 11 gives 128.
- R2: With mode 00 the counter keeps its value whatever ticks arrive.
- R3: In mode 01 the counter rises by one per advance from 0x0000 to 0xFFFF and wraps to 0x0000 on the next advance. The overflow flag is set on reaching 0xFFFF.
- R4: In mode 10 the counter rises from 0x0000 to the terminal value and returns to 0x0000 on the advance after it. The overflow flag is set on reaching the terminal value.
- R5: In mode 11 the counter rises to the terminal value, then falls one per advance to 0x0000, then rises again. The overflow flag is set on reaching 0x0000 while falling.
- R6: A read of address 0xE2 returns the live low count byte and stores the current high byte in a buffer. A read of 0xE3 returns that buffer.
- R7: Any write to address 0xE2 clears the 16-bit counter to 0x0000, whatever the data.
- R8: Writing 0 to a flag bit clears that flag, and writing 1 leaves it unchanged. A hardware set in the same cycle as a clearing write leaves the flag set.
- R9: The status/control byte at 0xE4 holds, from bit 7 down, the channel 2, 1 and 0 flags, the overflow flag (bit 4), the divider (bits 3:2) and the mode (bits 1:0). It resets to 0x00, and both count bytes read 0x00 after reset.
- R10: `irq` equals the overflow flag ANDed with the mask bit. The mask is bit 0 of address 0xD9 and resets to 1.
- R11: A pulse on `ch_evt[i]` sets the channel i flag.
- R12: A change of the divider field restarts the prescale count, so the next advance needs a full divisor of ticks.
- R13: The terminal value is written as two bytes: the low byte at 0xDA and the high byte at 0xDB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count tick, sampled each clock |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid in the cycle of the address |
| ch_evt | input | 3 | Set pulses for the channel 2..0 flags |
| irq | output | 1 | Masked overflow interrupt request |

## Verification
The hardest case to reach is a hardware set of the overflow flag in the same cycle as a software write that clears it. The bench sets the modulo terminal value to 5 and counts to 4 with single ticks. It then issues one bus cycle that asserts the status write and `tick` together, so the advance to the terminal value lands on the clearing edge. The full wrap at 0xFFFF comes from one long run with `tick` held high at divisor 1. The prescaler restart is shown by leaving a part-filled prescale count, changing the divider away and back, and checking that three further ticks do not advance the counter.

// File: rtl/timer16_pkg.sv
package timer16_pkg;

    typedef enum logic [1:0] {
        MD_HOLD = 2'b00,
        MD_FREE = 2'b01,
        MD_MOD  = 2'b10,
        MD_TRI  = 2'b11
    } tmode_e;

    typedef enum logic [1:0] {
        ST_HOLD,
        ST_UP,
        ST_DOWN
    } tstate_e;

    localparam logic [7:0] A_MASK   = 8'hD9;
    localparam logic [7:0] A_CMP_LO = 8'hDA;
    localparam logic [7:0] A_CMP_HI = 8'hDB;
    localparam logic [7:0] A_CNT_LO = 8'hE2;
    localparam logic [7:0] A_CNT_HI = 8'hE3;
    localparam logic [7:0] A_CTRL   = 8'hE4;

    // shift amounts of the four prescale divisors (1, 8, 32, 128)
    localparam int SH_DIV1 = 3;
    localparam int SH_DIV2 = 5;
    localparam int SH_DIV3 = 7;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import timer16_pkg::*;
#(
    parameter int PW = SH_DIV3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       hold,
    input  logic [1:0] div,
    output logic       step
);

    logic [PW-1:0] pcnt;
    logic [PW-1:0] limit;
    logic [1:0]    div_seen;
    logic          restart;

    always_comb begin
        unique case (div)
            2'd0:    limit = '0;
            2'd1:    limit = PW'((1 << SH_DIV1) - 1);
            2'd2:    limit = PW'((1 << SH_DIV2) - 1);
            default: limit = PW'((1 << SH_DIV3) - 1);
        endcase
    end

    assign restart = hold || (div != div_seen);
    assign step    = tick && !restart && (pcnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt     <= '0;
            div_seen <= 2'd0;
        end else begin
            div_seen <= div;
            if (restart)
                pcnt <= '0;
            else if (tick)
                pcnt <= (pcnt == limit) ? '0 : pcnt + PW'(1);
        end
    end

    // R1: any divisor above 1 can never give advances on back-to-back cycles
    p_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (step && div != 2'd0) |=> !step);

endmodule

// File: rtl/tmr_count_fsm.sv
module tmr_count_fsm
    import timer16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         clr,
    input  tmode_e       mode,
    input  logic [W-1:0] cmp,
    output logic [W-1:0] cnt,
    output logic         ovf_evt
);

    tstate_e      st, st_n;
    logic [W-1:0] cnt_n;

    // state and count registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_HOLD;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    // next state, next count and the overflow event
    always_comb begin
        st_n    = st;
        cnt_n   = cnt;
        ovf_evt = 1'b0;
        if (clr) begin
            cnt_n = '0;
            st_n  = (mode == MD_HOLD) ? ST_HOLD : ST_UP;
        end else if (mode == MD_HOLD) begin
            st_n = ST_HOLD;
        end else begin
            unique case (st)
                ST_HOLD, ST_UP: begin
                    st_n = ST_UP;
                    if (step) begin
                        unique case (mode)
                            MD_FREE: begin
                                cnt_n   = cnt + W'(1);
                                ovf_evt = (cnt_n == '1);
                            end
                            MD_MOD: begin
                                cnt_n   = (cnt >= cmp) ? '0 : cnt + W'(1);
                                ovf_evt = (cnt_n == cmp);
                            end
                            default: begin
                                if (cnt >= cmp && cnt != '0) begin
                                    cnt_n   = cnt - W'(1);
                                    st_n    = ST_DOWN;
                                    ovf_evt = (cnt_n == '0);
                                end else if (cnt < cmp) begin
                                    cnt_n = cnt + W'(1);
                                end
                            end
                        endcase
                    end
                end
                ST_DOWN: begin
                    if (mode != MD_TRI) begin
                        st_n = ST_UP;
                    end else if (step) begin
                        if (cnt == '0) begin
                            cnt_n = W'(1);
                            st_n  = ST_UP;
                        end else begin
                            cnt_n   = cnt - W'(1);
                            ovf_evt = (cnt_n == '0);
                        end
                    end
                end
                default: st_n = ST_HOLD;
            endcase
        end
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_HOLD && !clr) |=> $stable(cnt));

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

    p_mod_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_MOD && cnt <= cmp) |=> (cnt <= $past(cmp)));

    p_tri_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && mode == MD_TRI) |=> (cnt == '0));

endmodule

// File: rtl/prescaled_timer16.sv
module prescaled_timer16
    import timer16_pkg::*;
#(
    parameter int DW = 8,
    parameter int NCH = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [7:0]    bus_addr,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_rd,
    output logic [DW-1:0] bus_rdata,
    input  logic [NCH-1:0] ch_evt,
    output logic          irq
);

    localparam int W  = 2 * DW;
    localparam int NF = NCH + 1;

    tmode_e        mode_q;
    logic [1:0]    div_q;
    logic [NF-1:0] flag_q;     // [0] overflow, [NF-1:1] channels
    logic [NF-1:0] flag_set;
    logic          mask_q;
    logic [W-1:0]  cmp_q;
    logic [DW-1:0] hi_buf;
    logic [W-1:0]  cnt;
    logic          step, ovf_evt;
    logic          wr_ctrl, wr_clr, rd_lo;

    assign wr_ctrl  = bus_wr && bus_addr == A_CTRL;
    assign wr_clr   = bus_wr && bus_addr == A_CNT_LO;
    assign rd_lo    = bus_rd && bus_addr == A_CNT_LO;
    assign flag_set = {ch_evt, ovf_evt};

    tmr_prescaler #(.PW(SH_DIV3)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .hold  (mode_q == MD_HOLD),
        .div   (div_q),
        .step  (step)
    );

    tmr_count_fsm #(.W(W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .clr     (wr_clr),
        .mode    (mode_q),
        .cmp     (cmp_q),
        .cnt     (cnt),
        .ovf_evt (ovf_evt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MD_HOLD;
            div_q  <= 2'd0;
            mask_q <= 1'b1;
            cmp_q  <= '0;
            hi_buf <= '0;
        end else begin
            if (wr_ctrl) begin
                mode_q <= tmode_e'(bus_wdata[1:0]);
                div_q  <= bus_wdata[3:2];
            end
            if (bus_wr && bus_addr == A_MASK)   mask_q <= bus_wdata[0];
            if (bus_wr && bus_addr == A_CMP_LO) cmp_q[DW-1:0] <= bus_wdata;
            if (bus_wr && bus_addr == A_CMP_HI) cmp_q[W-1:DW] <= bus_wdata;
            if (rd_lo) hi_buf <= cnt[W-1:DW];
        end
    end

    // write-zero-to-clear flags; a hardware set in the same cycle wins
    for (genvar i = 0; i < NF; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flag_q[i] <= 1'b0;
            else
                flag_q[i] <= (wr_ctrl ? (flag_q[i] & bus_wdata[4+i]) : flag_q[i])
                             | flag_set[i];
        end
    end

    always_comb begin
        unique case (bus_addr)
            A_CNT_LO: bus_rdata = cnt[DW-1:0];
            A_CNT_HI: bus_rdata = hi_buf;
            A_CTRL:   bus_rdata = {flag_q[NF-1:1], flag_q[0], div_q, mode_q};
            A_CMP_LO: bus_rdata = cmp_q[DW-1:0];
            A_CMP_HI: bus_rdata = cmp_q[W-1:DW];
            A_MASK:   bus_rdata = {{(DW-1){1'b0}}, mask_q};
            default:  bus_rdata = '0;
        endcase
    end

    assign irq = flag_q[0] & mask_q;

    p_ovf_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> flag_q[0]);

    p_write_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && bus_wdata[4] && !ovf_evt) |=> (flag_q[0] == $past(flag_q[0])));

    p_hi_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lo |=> (hi_buf == $past(cnt[W-1:DW])));

    p_chan_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ch_evt[0] |=> flag_q[1]);

endmodule

// File: tb/prescaled_timer16_tb.sv
`timescale 1ns/1ps
module prescaled_timer16_tb_top;

    localparam logic [7:0] AD_MASK = 8'hD9;
    localparam logic [7:0] AD_CLO  = 8'hDA;
    localparam logic [7:0] AD_CHI  = 8'hDB;
    localparam logic [7:0] AD_LO   = 8'hE2;
    localparam logic [7:0] AD_HI   = 8'hE3;
    localparam logic [7:0] AD_CTL  = 8'hE4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic [2:0] ch_evt = 3'b000;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    prescaled_timer16 dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .ch_evt    (ch_evt),
        .irq       (irq)
    );

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic expect_reg(input logic [7:0] a, input logic [7:0] exp, input string tag);
        logic [7:0] v;
        rd(a, v);
        check({8'h00, v}, {8'h00, exp}, tag);
    endtask

    task automatic t_reset();
        check({15'd0, irq}, 16'd0, "R10 irq after reset");
        expect_reg(AD_CTL, 8'h00, "R9 ctrl reset");
        expect_reg(AD_LO, 8'h00, "R9 count low reset");
        expect_reg(AD_HI, 8'h00, "R9 count high reset");
        expect_reg(AD_MASK, 8'h01, "R10 mask reset");
    endtask

    task automatic t_hold();
        ticks(10);
        expect_reg(AD_LO, 8'h00, "R2 hold mode ignores ticks");
    endtask

    task automatic t_divider();
        wr(AD_CTL, 8'h01);
        wr(AD_LO, 8'h00);
        ticks(5);
        expect_reg(AD_LO, 8'h05, "R1 divisor 1");
        wr(AD_CTL, 8'h05);
        wr(AD_LO, 8'h00);
        ticks(16);
        expect_reg(AD_LO, 8'h02, "R1 divisor 8 after 16 ticks");
        ticks(7);
        expect_reg(AD_LO, 8'h02, "R1 divisor 8 after 23 ticks");
        ticks(1);
        expect_reg(AD_LO, 8'h03, "R1 divisor 8 after 24 ticks");
        // R12: partial prescale count, then change divider away and back
        ticks(5);
        wr(AD_CTL, 8'h01);
        wr(AD_CTL, 8'h05);
        ticks(3);
        expect_reg(AD_LO, 8'h03, "R12 prescaler restarted");
        wr(AD_CTL, 8'h09);
        wr(AD_LO, 8'h00);
        ticks(64);
        expect_reg(AD_LO, 8'h02, "R1 divisor 32");
        wr(AD_CTL, 8'h0D);
        wr(AD_LO, 8'h00);
        ticks(261);
        expect_reg(AD_LO, 8'h02, "R1 divisor 128");
    endtask

    task automatic t_modulo();
        wr(AD_CLO, 8'h05);
        wr(AD_CHI, 8'h00);
        expect_reg(AD_CLO, 8'h05, "R13 terminal low byte");
        wr(AD_CTL, 8'h02);
        wr(AD_LO, 8'h00);
        ticks(4);
        expect_reg(AD_CTL, 8'h02, "R4 no overflow before terminal");
        ticks(1);
        expect_reg(AD_LO, 8'h05, "R4 reaches terminal");
        expect_reg(AD_CTL, 8'h12, "R4 overflow at terminal");
        check({15'd0, irq}, 16'd1, "R10 irq with mask set");
        ticks(1);
        expect_reg(AD_LO, 8'h00, "R4 wrap to zero");
        wr(AD_MASK, 8'h00);
        check({15'd0, irq}, 16'd0, "R10 irq masked");
        wr(AD_MASK, 8'h01);
        check({15'd0, irq}, 16'd1, "R10 irq unmasked");
    endtask

    task automatic t_flags();
        wr(AD_CTL, 8'h12);
        expect_reg(AD_CTL, 8'h12, "R8 write 1 keeps overflow");
        wr(AD_CTL, 8'h02);
        expect_reg(AD_CTL, 8'h02, "R8 write 0 clears overflow");
        check({15'd0, irq}, 16'd0, "R10 irq after clear");
        // R8: hardware set and clearing write on the same edge
        wr(AD_LO, 8'h00);
        ticks(4);
        @(negedge clk);
        bus_addr = AD_CTL; bus_wdata = 8'h02; bus_wr = 1'b1; tick = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; tick = 1'b0;
        expect_reg(AD_CTL, 8'h12, "R8 set wins over clear");
        wr(AD_CTL, 8'h02);
        @(negedge clk);
        ch_evt = 3'b101;
        @(negedge clk);
        ch_evt = 3'b000;
        expect_reg(AD_CTL, 8'hA2, "R11 channel flags set");
        wr(AD_CTL, 8'h22);
        expect_reg(AD_CTL, 8'h22, "R8 clear one channel flag");
        wr(AD_CTL, 8'h02);
        expect_reg(AD_CTL, 8'h02, "R8 clear remaining flag");
    endtask

    task automatic t_triangle();
        wr(AD_CLO, 8'h03);
        wr(AD_CTL, 8'h03);
        wr(AD_LO, 8'h00);
        ticks(3);
        expect_reg(AD_LO, 8'h03, "R5 rise to terminal");
        expect_reg(AD_CTL, 8'h03, "R5 no overflow at top");
        ticks(2);
        expect_reg(AD_LO, 8'h01, "R5 falling");
        ticks(1);
        expect_reg(AD_LO, 8'h00, "R5 reaches zero");
        expect_reg(AD_CTL, 8'h13, "R5 overflow at zero");
        ticks(1);
        expect_reg(AD_LO, 8'h01, "R5 rises again");
        ticks(3);
        expect_reg(AD_LO, 8'h02, "R5 second turn");
    endtask

    task automatic t_latch();
        wr(AD_CTL, 8'h01);
        wr(AD_LO, 8'h00);
        ticks(300);
        expect_reg(AD_LO, 8'h2C, "R6 live low byte");
        ticks(300);
        expect_reg(AD_HI, 8'h01, "R6 high byte buffered");
        expect_reg(AD_LO, 8'h58, "R6 live low byte later");
        expect_reg(AD_HI, 8'h02, "R6 buffer refreshed");
        wr(AD_CTL, 8'h00);
        ticks(10);
        expect_reg(AD_LO, 8'h58, "R2 hold keeps value");
    endtask

    task automatic t_wrap();
        wr(AD_CTL, 8'h01);
        wr(AD_LO, 8'hA5);
        expect_reg(AD_LO, 8'h00, "R7 clear low");
        expect_reg(AD_HI, 8'h00, "R7 clear high");
        ticks(65535);
        expect_reg(AD_LO, 8'hFF, "R3 low at full");
        expect_reg(AD_HI, 8'hFF, "R3 high at full");
        expect_reg(AD_CTL, 8'h11, "R3 overflow at full");
        ticks(1);
        expect_reg(AD_LO, 8'h00, "R3 wrap low");
        expect_reg(AD_HI, 8'h00, "R3 wrap high");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hold();
        t_divider();
        t_modulo();
        t_flags();
        t_triangle();
        t_latch();
        t_wrap();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule